// File: doc/BRIEF.md
# Two-Port RAM with Selectable Read Pipelining

This block is a small simple dual-port memory, 64 words of 12 bits by default, with one write port and one read port. Writes are always synchronous to the write clock and use an active-low write strobe. The read side can be built four ways: a purely combinational read, a read with a registered address, a read with a registered output, or with both registers. This lets the integrator pick zero, one or two cycles of read latency to suit the timing budget around the memory.

Each of the two optional read registers has its own active-high load enable, active-low synchronous clear and active-low asynchronous clear. A read-port enable gates both registers. A parameter picks whether the two ports share one clock input or take separate write and read clock inputs.

Top module: `rp_ram2p`

## Requirements
- R1: With `wr_n` low, the rising write-clock edge stores `wdata` at word `waddr`. Every one of the 64 words can be written and read back.
- R2: With `wr_n` high, a clock edge leaves the storage unchanged, whatever `waddr` and `wdata` are.
- R3: With both read registers disabled (`ADDR_REG=0`, `DATA_REG=0`), `rdata` shows the word at `raddr` in the same cycle, with no clock edge needed.
- R4: With only the address register enabled, `rdata` shows the word at the `raddr` captured on the last loading read-clock edge (latency 1).
- R5: With only the data register enabled, latency is 1 read-clock edge. With both registers enabled, latency is 2 edges.
- R6: While `rd_en` is low, every enabled read register holds its value.
- R7: A read register whose own load enable (`raddr_ld` or `rdata_ld`) is low holds its value. The other register still loads.
- R8: A low synchronous clear clears its register to zero on the next read-clock edge, even when load is requested. A cleared address register selects word 0.
- R9: A low asynchronous clear forces its register to zero at once, without a clock edge, and overrides the synchronous clear and the load.
- R10: With the data register enabled, a read and a write to the same word on the same edge return the old contents. The next read returns the new word.
- R11: With `SHARED_CLK=1`, both ports run on `clk` and `wclk`/`rclk` are ignored. With `SHARED_CLK=0`, writes use `wclk`, reads use `rclk`, and `clk` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock when `SHARED_CLK=1` |
| wclk | input | 1 | Write clock when `SHARED_CLK=0` |
| rclk | input | 1 | Read clock when `SHARED_CLK=0` |
| rd_en | input | 1 | Read-port enable, active high; gates both read registers |
| raddr | input | 6 | Read word address |
| raddr_ld | input | 1 | Address register load enable, active high |
| raddr_srst_n | input | 1 | Address register synchronous clear, active low |
| raddr_arst_n | input | 1 | Address register asynchronous clear, active low |
| rdata | output | 12 | Read word |
| rdata_ld | input | 1 | Data register load enable, active high |
| rdata_srst_n | input | 1 | Data register synchronous clear, active low |
| rdata_arst_n | input | 1 | Data register asynchronous clear, active low |
| waddr | input | 6 | Write word address |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 12 | Write word |

## Verification
The hardest case to reach is a collision: one edge where a write and a read hit the same word, with the data register present. The port has to return the old word on that edge and the new word on the next one. The bench gets there by parking the read address on a word that is already known. It lets the data register settle, then drives a write to that same word with a fresh value on the following edge. It compares the registered instance with a combinational instance that shares the same inputs. The clear-priority cases need the same care, since a load must be requested while each clear is active. So the bench holds load and read enable high while it pulses the synchronous clear, and again while it pulses the asynchronous clear.

// File: rtl/rp_pkg.sv
// Package rp_pkg
// Purpose : shared defaults and the read-mode encoding for the two-port RAM.
// Assumes : nothing; pure declarations.
package rp_pkg;

    localparam int unsigned RP_DEPTH_DEF = 64;
    localparam int unsigned RP_WIDTH_DEF = 12;

    // Read path flavour, derived from the two register-enable parameters
    typedef enum logic [1:0] {
        RD_COMB  = 2'b00,
        RD_AREG  = 2'b01,
        RD_DREG  = 2'b10,
        RD_BOTH  = 2'b11
    } rd_mode_t;

    // Turn the pair of register selections into a mode value
    function automatic rd_mode_t rd_mode(input bit use_areg, input bit use_dreg);
        return rd_mode_t'({use_dreg, use_areg});
    endfunction

    // Read latency in read-clock edges for a given mode
    function automatic int unsigned rd_latency(input rd_mode_t m);
        return int'(m[0]) + int'(m[1]);
    endfunction

endpackage

// File: rtl/rp_clksel.sv
// Module rp_clksel
// Purpose : chooses the write and read clocks, either one shared input or two
//           independent inputs, fixed at elaboration.
// Assumes : the unused clock inputs are tied off by the integrator.
module rp_clksel #(
    parameter bit SHARED = 1'b1
) (
    input  logic clk,
    input  logic wclk,
    input  logic rclk,
    output logic wr_clk,
    output logic rd_clk
);

    generate
        if (SHARED) begin : g_shared
            logic unused_sep;
            // route the common clock to both ports
            assign wr_clk = clk;
            assign rd_clk = clk;
            assign unused_sep = wclk ^ rclk;
        end else begin : g_split
            logic unused_com;
            // route the independent clocks to their ports
            assign wr_clk = wclk;
            assign rd_clk = rclk;
            assign unused_com = clk;
        end
    endgenerate

endmodule

// File: rtl/rp_store.sv
// Module rp_store
// Purpose : the word array. One synchronous write port with active-low strobe,
//           one combinational read port.
// Assumes : addresses are in range (DEPTH is a power of two by default).
module rp_store #(
    parameter int unsigned DEPTH = rp_pkg::RP_DEPTH_DEF,
    parameter int unsigned WIDTH = rp_pkg::RP_WIDTH_DEF,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             wr_n,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rword
);

    logic [WIDTH-1:0] words [DEPTH];

    // commit a word on the write clock when the strobe is low
    always_ff @(posedge wr_clk) begin
        if (!wr_n) begin
            words[waddr] <= wdata;
        end
    end

    // look up the addressed word without a clock
    always_comb begin
        rword = words[raddr];
    end

endmodule

// File: rtl/rp_stage.sv
// Module rp_stage
// Purpose : one optional read-path register with load enable, synchronous
//           clear and asynchronous clear; a wire when USE is 0.
// Assumes : priority is async clear, then sync clear, then load.
module rp_stage #(
    parameter int unsigned W   = 8,
    parameter bit          USE = 1'b1
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic         srst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (USE) begin : g_reg
            logic [W-1:0] q_r;
            // clear or load the stage register
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    q_r <= '0;
                end else if (!srst_n) begin
                    q_r <= '0;
                end else if (ld) begin
                    q_r <= d;
                end
            end
            assign q = q_r;
        end else begin : g_wire
            logic unused_ctl;
            // pass the value straight through
            assign q = d;
            assign unused_ctl = clk ^ arst_n ^ srst_n ^ ld;
        end
    endgenerate

endmodule

// File: rtl/rp_ram2p.sv
// Module rp_ram2p
// Purpose : simple dual-port RAM (one write port, one read port) with
//           optional address and data registers on the read path and a
//           choice of one shared clock or independent clocks.
// Assumes : all controls are synchronous to the clock of their own port,
//           except the two asynchronous clears.
module rp_ram2p #(
    parameter int unsigned DEPTH      = rp_pkg::RP_DEPTH_DEF,
    parameter int unsigned WIDTH      = rp_pkg::RP_WIDTH_DEF,
    parameter bit          ADDR_REG   = 1'b1,
    parameter bit          DATA_REG   = 1'b1,
    parameter bit          SHARED_CLK = 1'b1,
    localparam int unsigned AW        = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rd_en,
    input  logic [AW-1:0]    raddr,
    input  logic             raddr_ld,
    input  logic             raddr_srst_n,
    input  logic             raddr_arst_n,
    output logic [WIDTH-1:0] rdata,
    input  logic             rdata_ld,
    input  logic             rdata_srst_n,
    input  logic             rdata_arst_n,
    input  logic [AW-1:0]    waddr,
    input  logic             wr_n,
    input  logic [WIDTH-1:0] wdata
);

    import rp_pkg::*;

    localparam rd_mode_t    MODE    = rd_mode(ADDR_REG, DATA_REG);
    localparam int unsigned LATENCY = rd_latency(MODE);

    logic             wr_clk_i;
    logic             rd_clk_i;
    logic [AW-1:0]    addr_q;
    logic [WIDTH-1:0] word_rd;
    logic             addr_load;
    logic             data_load;

    // port enable gates both stage loads
    assign addr_load = rd_en & raddr_ld;
    assign data_load = rd_en & rdata_ld;

    rp_clksel #(.SHARED(SHARED_CLK)) u_clk (
        .clk    (clk),
        .wclk   (wclk),
        .rclk   (rclk),
        .wr_clk (wr_clk_i),
        .rd_clk (rd_clk_i)
    );

    rp_stage #(.W(AW), .USE(ADDR_REG)) u_astage (
        .clk    (rd_clk_i),
        .arst_n (raddr_arst_n),
        .srst_n (raddr_srst_n),
        .ld     (addr_load),
        .d      (raddr),
        .q      (addr_q)
    );

    rp_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .wr_clk (wr_clk_i),
        .wr_n   (wr_n),
        .waddr  (waddr),
        .wdata  (wdata),
        .raddr  (addr_q),
        .rword  (word_rd)
    );

    rp_stage #(.W(WIDTH), .USE(DATA_REG)) u_dstage (
        .clk    (rd_clk_i),
        .arst_n (rdata_arst_n),
        .srst_n (rdata_srst_n),
        .ld     (data_load),
        .d      (word_rd),
        .q      (rdata)
    );

    // elaboration-time sanity on the derived latency
    initial begin
        if (LATENCY > 2) $display("rp_ram2p: unexpected latency %0d", LATENCY);
    end

endmodule

// File: rtl/rp_ram2p_chk.sv
// Module rp_ram2p_chk
// Purpose : property checks on the two-port RAM, bound into every instance.
// Assumes : clocks are the internal port clocks of the bound instance.
module rp_ram2p_chk #(
    parameter int unsigned AW       = 6,
    parameter int unsigned WIDTH    = 12,
    parameter bit          ADDR_REG = 1'b1,
    parameter bit          DATA_REG = 1'b1
) (
    input logic             wr_clk_i,
    input logic             rd_clk_i,
    input logic             rd_en,
    input logic [AW-1:0]    raddr,
    input logic             raddr_ld,
    input logic             raddr_srst_n,
    input logic             raddr_arst_n,
    input logic [AW-1:0]    addr_q,
    input logic [WIDTH-1:0] rdata,
    input logic             rdata_ld,
    input logic             rdata_srst_n,
    input logic             rdata_arst_n,
    input logic [AW-1:0]    waddr,
    input logic             wr_n,
    input logic [WIDTH-1:0] wdata
);

    generate
        if (DATA_REG) begin : g_d
            AST_DATA_SCLR: assert property (@(posedge rd_clk_i) disable iff (!rdata_arst_n)
                !rdata_srst_n |=> (rdata == '0)); // R8
            AST_DATA_HOLD: assert property (@(posedge rd_clk_i) disable iff (!rdata_arst_n)
                (rdata_srst_n && !(rd_en && rdata_ld)) |=> $stable(rdata)); // R7
            AST_DATA_ACLR: assert property (@(posedge rd_clk_i)
                !rdata_arst_n |-> (rdata == '0)); // R9
        end
        if (ADDR_REG) begin : g_a
            AST_ADDR_HOLD: assert property (@(posedge rd_clk_i) disable iff (!raddr_arst_n)
                (raddr_srst_n && !rd_en) |=> $stable(addr_q)); // R6
            AST_ADDR_SCLR: assert property (@(posedge rd_clk_i) disable iff (!raddr_arst_n)
                !raddr_srst_n |=> (addr_q == '0)); // R8
        end
        if (!ADDR_REG && !DATA_REG) begin : g_c
            AST_COMB_WRITE: assert property (@(posedge wr_clk_i) disable iff (!rdata_arst_n)
                (!wr_n && raddr == waddr) |=>
                ((raddr != $past(raddr)) || (rdata == $past(wdata)))); // R3
        end
    endgenerate

endmodule

bind rp_ram2p rp_ram2p_chk #(
    .AW(AW), .WIDTH(WIDTH), .ADDR_REG(ADDR_REG), .DATA_REG(DATA_REG)
) u_chk (
    .wr_clk_i     (wr_clk_i),
    .rd_clk_i     (rd_clk_i),
    .rd_en        (rd_en),
    .raddr        (raddr),
    .raddr_ld     (raddr_ld),
    .raddr_srst_n (raddr_srst_n),
    .raddr_arst_n (raddr_arst_n),
    .addr_q       (addr_q),
    .rdata        (rdata),
    .rdata_ld     (rdata_ld),
    .rdata_srst_n (rdata_srst_n),
    .rdata_arst_n (rdata_arst_n),
    .waddr        (waddr),
    .wr_n         (wr_n),
    .wdata        (wdata)
);

// File: tb/sim_rp_ram2p.sv
// Bench for rp_ram2p: four read-path variants share one stimulus stream.
module sim_rp_ram2p;

    localparam int PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 12;
    localparam int NW = 64;

    logic clk = 1'b0;
    logic rd_en = 1'b0, raddr_ld = 1'b1, raddr_srst_n = 1'b1, raddr_arst_n = 1'b0;
    logic rdata_ld = 1'b1, rdata_srst_n = 1'b1, rdata_arst_n = 1'b0;
    logic wr_n = 1'b1;
    logic [AW-1:0] raddr = '0, waddr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] q_both, q_comb, q_areg, q_dreg;
    logic [DW-1:0] model [NW];
    int total = 0, bad = 0;

    always #(PERIOD/2) clk = ~clk;

    // both registers, independent clocks; shared input tied off (R11)
    rp_ram2p #(.ADDR_REG(1), .DATA_REG(1), .SHARED_CLK(0)) u0 (
        .clk(1'b0), .wclk(clk), .rclk(clk), .rd_en(rd_en), .raddr(raddr),
        .raddr_ld(raddr_ld), .raddr_srst_n(raddr_srst_n), .raddr_arst_n(raddr_arst_n),
        .rdata(q_both), .rdata_ld(rdata_ld), .rdata_srst_n(rdata_srst_n),
        .rdata_arst_n(rdata_arst_n), .waddr(waddr), .wr_n(wr_n), .wdata(wdata));
    // combinational read, shared clock; separate inputs tied off
    rp_ram2p #(.ADDR_REG(0), .DATA_REG(0), .SHARED_CLK(1)) u1 (
        .clk(clk), .wclk(1'b0), .rclk(1'b0), .rd_en(rd_en), .raddr(raddr),
        .raddr_ld(raddr_ld), .raddr_srst_n(raddr_srst_n), .raddr_arst_n(raddr_arst_n),
        .rdata(q_comb), .rdata_ld(rdata_ld), .rdata_srst_n(rdata_srst_n),
        .rdata_arst_n(rdata_arst_n), .waddr(waddr), .wr_n(wr_n), .wdata(wdata));
    rp_ram2p #(.ADDR_REG(1), .DATA_REG(0), .SHARED_CLK(1)) u2 (
        .clk(clk), .wclk(1'b0), .rclk(1'b0), .rd_en(rd_en), .raddr(raddr),
        .raddr_ld(raddr_ld), .raddr_srst_n(raddr_srst_n), .raddr_arst_n(raddr_arst_n),
        .rdata(q_areg), .rdata_ld(rdata_ld), .rdata_srst_n(rdata_srst_n),
        .rdata_arst_n(rdata_arst_n), .waddr(waddr), .wr_n(wr_n), .wdata(wdata));
    rp_ram2p #(.ADDR_REG(0), .DATA_REG(1), .SHARED_CLK(1)) u3 (
        .clk(clk), .wclk(1'b0), .rclk(1'b0), .rd_en(rd_en), .raddr(raddr),
        .raddr_ld(raddr_ld), .raddr_srst_n(raddr_srst_n), .raddr_arst_n(raddr_arst_n),
        .rdata(q_dreg), .rdata_ld(rdata_ld), .rdata_srst_n(rdata_srst_n),
        .rdata_arst_n(rdata_arst_n), .waddr(waddr), .wr_n(wr_n), .wdata(wdata));

    function automatic logic [DW-1:0] pat(input int a);
        return DW'((a * 37 + 5) & 12'hFFF);
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step();
        #1;
        chk("R9 reset u0", q_both, '0);
        chk("R9 reset u3", q_dreg, '0);
        raddr_arst_n = 1'b1;
        rdata_arst_n = 1'b1;

        // R1: fill every word
        for (int a = 0; a < NW; a++) begin
            step();
            waddr = AW'(a); wdata = pat(a); wr_n = 1'b0;
            model[a] = pat(a);
        end
        step();
        wr_n = 1'b1;

        // R2: strobe high must not write
        waddr = 6'd7; wdata = 12'hBAD;
        step();
        raddr = 6'd7;
        #1;
        chk("R2 no write", q_comb, model[7]);

        // R1 R3 R4 R5 R11: sweep all addresses
        rd_en = 1'b1;
        for (int a = 0; a < NW; a++) begin
            step();
            raddr = AW'(a);
            #1;
            chk("R3 comb read", q_comb, model[a]);
            step();
            #1;
            chk("R4 addr reg", q_areg, model[a]);
            chk("R5 data reg", q_dreg, model[a]);
            step();
            #1;
            chk("R1 R5 R11 both regs", q_both, model[a]);
        end

        // R6: port disabled holds registers
        step();
        rd_en = 1'b0; raddr = 6'd1;
        step(); step();
        #1;
        chk("R6 hold u0", q_both, model[63]);
        chk("R6 hold u2", q_areg, model[63]);
        chk("R6 hold u3", q_dreg, model[63]);
        chk("R6 comb follows", q_comb, model[1]);

        // R7: per-stage load enables
        step();
        rd_en = 1'b1; rdata_ld = 1'b0; raddr = 6'd2;
        step(); step();
        #1;
        chk("R7 data hold u3", q_dreg, model[63]);
        chk("R7 data hold u0", q_both, model[63]);
        chk("R7 addr loads u2", q_areg, model[2]);
        step();
        raddr_ld = 1'b0; rdata_ld = 1'b1; raddr = 6'd4;
        step(); step();
        #1;
        chk("R7 addr hold u2", q_areg, model[2]);
        chk("R7 addr hold u0", q_both, model[2]);
        chk("R7 data loads u3", q_dreg, model[4]);

        // R8: synchronous clear beats load
        step();
        raddr_ld = 1'b1; rdata_srst_n = 1'b0; raddr_srst_n = 1'b0; raddr = 6'd9;
        step();
        #1;
        chk("R8 sclr u3", q_dreg, '0);
        chk("R8 sclr u0", q_both, '0);
        chk("R8 sclr addr u2", q_areg, model[0]);
        raddr_srst_n = 1'b1; rdata_srst_n = 1'b1;
        step(); step();
        #1;
        chk("R8 release u0", q_both, model[9]);

        // R9: asynchronous clear acts before any edge
        #1;
        rdata_arst_n = 1'b0; raddr_arst_n = 1'b0; rdata_srst_n = 1'b1;
        #1;
        chk("R9 aclr u3", q_dreg, '0);
        chk("R9 aclr u0", q_both, '0);
        chk("R9 aclr addr u2", q_areg, model[0]);
        step();
        rdata_srst_n = 1'b0;
        step();
        #1;
        chk("R9 aclr over sclr", q_dreg, '0);
        rdata_arst_n = 1'b1; raddr_arst_n = 1'b1; rdata_srst_n = 1'b1;

        // R10: same-word read and write on one edge
        step();
        raddr = 6'd5;
        step();
        waddr = 6'd5; wdata = 12'h5A5; wr_n = 1'b0;
        step();
        wr_n = 1'b1;
        #1;
        chk("R10 old data", q_dreg, model[5]);
        chk("R10 comb sees new", q_comb, 12'h5A5);
        model[5] = 12'h5A5;
        step();
        #1;
        chk("R10 new data", q_dreg, model[5]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule